// File: doc/BRIEF.md
# Scratch Mailbox with Toggle Interrupt

This block sits on the codec side of an audio link. It holds two 32-bit scratch registers that a host reaches through 12-bit command verbs, each carrying an 8-bit payload. The host reads a register whole and writes it one byte at a time. A display-side peer controller watches both registers through a read-only port. It is told through a one-cycle interrupt pulse that the audio format published in scratch register 0 has changed.

Scratch register 0 carries a 16-bit audio format code in bits 15:0, bits 29:16 unused, a format-valid flag in bit 30 and a trigger bit in bit 31. A valid flag of 0 tells the peer to shut its audio path. A static mode input selects how the peer is notified. In toggle mode (mode 0) the interrupt fires whenever a byte-3 write flips bit 31, in either direction. In doorbell mode (mode 1) bit 31 is plain storage, and a dedicated verb with a non-zero payload fires the interrupt.

Top module: `scratch_mailbox`

## Requirements
- R1: After synchronous reset both scratch registers read zero, the interrupt output is low and no response is valid.
- R2: Verbs 0xFA7, 0xFA8, 0xFA9 and 0xFAA write the payload into bytes 0, 1, 2 and 3 of scratch register 0 and leave the other bytes unchanged; the new value appears on the peer port in the cycle after the command.
- R3: Verbs 0xFAC, 0xFAD, 0xFAE and 0xFAF write the payload into bytes 0, 1, 2 and 3 of scratch register 1 in the same way.
- R4: Every accepted command gives a response valid for one cycle, one cycle after acceptance; verb 0xFA6 returns the full value of scratch register 0 and verb 0xFAB that of scratch register 1.
- R5: Any other verb changes neither register, returns response data of zero and raises no interrupt in toggle mode.
- R6: In toggle mode a write with verb 0xFAA whose payload bit 7 differs from the current bit 31 of scratch register 0 raises a one-cycle interrupt pulse in the cycle after the command; a write that keeps bit 31 unchanged raises none.
- R7: In doorbell mode verb 0xF80 with a non-zero payload raises a one-cycle interrupt pulse in the cycle after the command; a zero payload raises none, and changing bit 31 raises none.
- R8: In toggle mode verb 0xF80 has no effect on the interrupt or the registers.
- R9: In the cycle that the interrupt pulse is high, the peer port already shows the register contents written by the causing command, and the format-valid status output equals bit 30 of scratch register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Notification mode, static: 0 toggle, 1 doorbell |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_verb_i | input | 12 | Command verb |
| cmd_payload_i | input | 8 | Command payload |
| rsp_valid_o | output | 1 | Response valid, one cycle after a command |
| rsp_data_o | output | 32 | Response data |
| peer_scratch0_o | output | 32 | Peer view of scratch register 0 |
| peer_scratch1_o | output | 32 | Peer view of scratch register 1 |
| peer_fmt_valid_o | output | 1 | Format-valid flag of scratch register 0 |
| peer_intr_o | output | 1 | One-cycle interrupt pulse to the peer |

## Verification
The assertions take the mode input as fixed between resets, so that a pulse is always judged against the mode under which its command was accepted, and they take one command per cycle with no command during reset. The stimulus changes the mode only while reset is held. It issues commands one per cycle through a single task, and it covers both directions of the trigger flip, a repeated identical trigger write, zero and non-zero doorbell payloads, and the doorbell verb issued in the wrong mode.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    parameter int VERB_W    = 12;
    parameter int PAY_W     = 8;
    parameter int NUM_REGS  = 2;
    parameter int REG_BYTES = 4;

    localparam int REG_W     = REG_BYTES * PAY_W;
    localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int BYTE_IDX_W = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1;

    // first read verb; each register takes one read verb then one verb per byte
    localparam logic [VERB_W-1:0] SCR_BASE_VERB  = 12'hFA6;
    localparam logic [VERB_W-1:0] DOORBELL_VERB  = 12'hF80;

    localparam int TRIG_BIT  = REG_W - 1;
    localparam int VALID_BIT = REG_W - 2;

    typedef enum logic {
        NOTIFY_TOGGLE   = 1'b0,
        NOTIFY_DOORBELL = 1'b1
    } notify_mode_e;

    typedef struct packed {
        logic                  is_read;
        logic [REG_IDX_W-1:0]  rd_sel;
        logic                  is_write;
        logic [REG_IDX_W-1:0]  wr_reg;
        logic [BYTE_IDX_W-1:0] wr_byte;
        logic                  is_doorbell;
    } cmd_dec_t;

    function automatic logic [VERB_W-1:0] read_verb(int r);
        return VERB_W'(int'(SCR_BASE_VERB) + r * (REG_BYTES + 1));
    endfunction

    function automatic logic [VERB_W-1:0] write_verb(int r, int b);
        return VERB_W'(int'(read_verb(r)) + 1 + b);
    endfunction

    function automatic cmd_dec_t decode_cmd(logic vld, logic [VERB_W-1:0] verb);
        cmd_dec_t d;
        d = '0;
        if (vld) begin
            if (verb == DOORBELL_VERB) d.is_doorbell = 1'b1;
            for (int r = 0; r < NUM_REGS; r++) begin
                if (verb == read_verb(r)) begin
                    d.is_read = 1'b1;
                    d.rd_sel  = REG_IDX_W'(r);
                end
                for (int b = 0; b < REG_BYTES; b++) begin
                    if (verb == write_verb(r, b)) begin
                        d.is_write = 1'b1;
                        d.wr_reg   = REG_IDX_W'(r);
                        d.wr_byte  = BYTE_IDX_W'(b);
                    end
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic              cmd_valid_i,
    input  logic [VERB_W-1:0] cmd_verb_i,
    output cmd_dec_t          dec_o
);

    always_comb begin
        dec_o = decode_cmd(cmd_valid_i, cmd_verb_i);
    end

endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
    import mbx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid_i,
    input  cmd_dec_t                      dec_i,
    input  logic [PAY_W-1:0]              payload_i,
    output logic [NUM_REGS-1:0][REG_W-1:0] regs_o,
    output logic                          rsp_valid_o,
    output logic [REG_W-1:0]              rsp_data_o
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [REG_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (dec_i.is_write && dec_i.wr_reg == REG_IDX_W'(r)) begin
                for (int b = 0; b < REG_BYTES; b++) begin
                    if (dec_i.wr_byte == BYTE_IDX_W'(b)) q[b*PAY_W +: PAY_W] <= payload_i;
                end
            end
        end

        assign regs_o[r] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            rsp_valid_o <= cmd_valid_i;
            rsp_data_o  <= dec_i.is_read ? regs_o[dec_i.rd_sel] : '0;
        end
    end

endmodule

// File: rtl/mbx_notify.sv
module mbx_notify
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  notify_mode_e     mode_i,
    input  cmd_dec_t         dec_i,
    input  logic [PAY_W-1:0] payload_i,
    input  logic             cur_trig_i,
    output logic             intr_o
);

    logic toggle_fire;
    logic bell_fire;

    always_comb begin
        toggle_fire = (mode_i == NOTIFY_TOGGLE) && dec_i.is_write &&
                      (dec_i.wr_reg == '0) &&
                      (dec_i.wr_byte == BYTE_IDX_W'(REG_BYTES - 1)) &&
                      (payload_i[PAY_W-1] != cur_trig_i);
        bell_fire   = (mode_i == NOTIFY_DOORBELL) && dec_i.is_doorbell &&
                      (payload_i != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) intr_o <= 1'b0;
        else     intr_o <= toggle_fire | bell_fire;
    end

endmodule

// File: rtl/scratch_mailbox.sv
module scratch_mailbox
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              cmd_valid_i,
    input  logic [VERB_W-1:0] cmd_verb_i,
    input  logic [PAY_W-1:0]  cmd_payload_i,
    output logic              rsp_valid_o,
    output logic [REG_W-1:0]  rsp_data_o,
    output logic [REG_W-1:0]  peer_scratch0_o,
    output logic [REG_W-1:0]  peer_scratch1_o,
    output logic              peer_fmt_valid_o,
    output logic              peer_intr_o
);

    cmd_dec_t                      dec;
    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    notify_mode_e                  mode;

    assign mode = notify_mode_e'(mode_i);

    mbx_decode u_decode (
        .cmd_valid_i (cmd_valid_i),
        .cmd_verb_i  (cmd_verb_i),
        .dec_o       (dec)
    );

    mbx_regfile u_regfile (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid_i),
        .dec_i       (dec),
        .payload_i   (cmd_payload_i),
        .regs_o      (regs),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o)
    );

    mbx_notify u_notify (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .dec_i      (dec),
        .payload_i  (cmd_payload_i),
        .cur_trig_i (regs[0][TRIG_BIT]),
        .intr_o     (peer_intr_o)
    );

    assign peer_scratch0_o  = regs[0];
    assign peer_scratch1_o  = regs[1];
    assign peer_fmt_valid_o = regs[0][VALID_BIT];

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mode_i,
    input logic              cmd_valid_i,
    input logic [VERB_W-1:0] cmd_verb_i,
    input logic [PAY_W-1:0]  cmd_payload_i,
    input logic              rsp_valid_o,
    input logic [REG_W-1:0]  peer_scratch0_o,
    input logic [REG_W-1:0]  peer_scratch1_o,
    input logic              peer_intr_o
);

    logic trig_wr;
    logic known;
    assign trig_wr = cmd_valid_i && cmd_verb_i == 12'hFAA;
    assign known   = (cmd_verb_i >= 12'hFA6) && (cmd_verb_i <= 12'hFAF);

    // R4: one response per accepted command, a cycle later
    a_r4_rsp_latency: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_i |=> rsp_valid_o);

    // R5: unknown verbs leave both registers untouched
    a_r5_unknown_stable: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && !known) |=> ($stable(peer_scratch0_o) && $stable(peer_scratch1_o)));

    // R6: a flip of the trigger bit fires in toggle mode
    a_r6_toggle_fires: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && trig_wr && cmd_payload_i[7] != peer_scratch0_o[31]) |=> peer_intr_o);

    // R6: in toggle mode a pulse always follows a flip of bit 31
    a_r6_toggle_cause: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && peer_intr_o) |-> ($past(peer_scratch0_o[31]) != peer_scratch0_o[31]));

    // R7: doorbell with non-zero payload fires
    a_r7_bell_fires: assert property (@(posedge clk) disable iff (rst)
        (mode_i && cmd_valid_i && cmd_verb_i == 12'hF80 && cmd_payload_i != 8'h00) |=> peer_intr_o);

    // R7: in doorbell mode only the doorbell verb can cause a pulse
    a_r7_bell_cause: assert property (@(posedge clk) disable iff (rst)
        (mode_i && peer_intr_o) |-> $past(cmd_valid_i && cmd_verb_i == 12'hF80 && cmd_payload_i != 8'h00));

    // R6 R7: pulses come only from an accepted command
    a_r6_pulse_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        peer_intr_o |-> $past(cmd_valid_i));

endmodule

bind scratch_mailbox mbx_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .mode_i          (mode_i),
    .cmd_valid_i     (cmd_valid_i),
    .cmd_verb_i      (cmd_verb_i),
    .cmd_payload_i   (cmd_payload_i),
    .rsp_valid_o     (rsp_valid_o),
    .peer_scratch0_o (peer_scratch0_o),
    .peer_scratch1_o (peer_scratch1_o),
    .peer_intr_o     (peer_intr_o)
);

// File: tb/scratch_mailbox_tb.sv
module scratch_mailbox_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_i = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [11:0] cmd_verb_i = '0;
    logic [7:0]  cmd_payload_i = '0;
    logic        rsp_valid_o;
    logic [31:0] rsp_data_o;
    logic [31:0] peer_scratch0_o;
    logic [31:0] peer_scratch1_o;
    logic        peer_fmt_valid_o;
    logic        peer_intr_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    scratch_mailbox u_dut (
        .clk              (clk),
        .rst              (rst),
        .mode_i           (mode_i),
        .cmd_valid_i      (cmd_valid_i),
        .cmd_verb_i       (cmd_verb_i),
        .cmd_payload_i    (cmd_payload_i),
        .rsp_valid_o      (rsp_valid_o),
        .rsp_data_o       (rsp_data_o),
        .peer_scratch0_o  (peer_scratch0_o),
        .peer_scratch1_o  (peer_scratch1_o),
        .peer_fmt_valid_o (peer_fmt_valid_o),
        .peer_intr_o      (peer_intr_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // presents one command; returns at the negedge after it was accepted
    task automatic send(logic [11:0] verb, logic [7:0] pay);
        @(negedge clk);
        cmd_valid_i   = 1'b1;
        cmd_verb_i    = verb;
        cmd_payload_i = pay;
        @(negedge clk);
        cmd_valid_i   = 1'b0;
        cmd_verb_i    = '0;
        cmd_payload_i = '0;
    endtask

    task automatic do_reset(logic mode);
        @(negedge clk);
        rst    = 1'b1;
        mode_i = mode;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 scratch0", peer_scratch0_o, 32'h0);
        check("R1 scratch1", peer_scratch1_o, 32'h0);
        check("R1 intr", {31'b0, peer_intr_o}, 32'h0);
        check("R1 rsp_valid", {31'b0, rsp_valid_o}, 32'h0);
    endtask

    task automatic t_reg0_bytes();
        send(12'hFA7, 8'h11);
        check("R2 byte0", peer_scratch0_o, 32'h0000_0011);
        send(12'hFA8, 8'h22);
        send(12'hFA9, 8'h33);
        send(12'hFAA, 8'h40);
        check("R2 all bytes", peer_scratch0_o, 32'h4033_2211);
        check("R9 fmt valid", {31'b0, peer_fmt_valid_o}, 32'h1);
        check("R6 no flip no pulse", {31'b0, peer_intr_o}, 32'h0);
        send(12'hFA8, 8'hAB);
        check("R2 byte1 only", peer_scratch0_o, 32'h4033_AB11);
    endtask

    task automatic t_reg1_bytes();
        send(12'hFAC, 8'h01);
        send(12'hFAD, 8'h02);
        send(12'hFAE, 8'h03);
        send(12'hFAF, 8'h84);
        check("R3 scratch1", peer_scratch1_o, 32'h8403_0201);
        check("R3 scratch0 untouched", peer_scratch0_o, 32'h4033_AB11);
        check("R3 no pulse", {31'b0, peer_intr_o}, 32'h0);
    endtask

    task automatic t_reads();
        send(12'hFA6, 8'h00);
        check("R4 rsp_valid", {31'b0, rsp_valid_o}, 32'h1);
        check("R4 read scratch0", rsp_data_o, 32'h4033_AB11);
        @(negedge clk);
        check("R4 rsp one cycle", {31'b0, rsp_valid_o}, 32'h0);
        send(12'hFAB, 8'h00);
        check("R4 read scratch1", rsp_data_o, 32'h8403_0201);
    endtask

    task automatic t_unknown();
        send(12'hFB0, 8'hFF);
        check("R5 rsp zero", rsp_data_o, 32'h0);
        check("R5 rsp valid", {31'b0, rsp_valid_o}, 32'h1);
        send(12'hFA5, 8'hFF);
        check("R5 scratch0 kept", peer_scratch0_o, 32'h4033_AB11);
        check("R5 scratch1 kept", peer_scratch1_o, 32'h8403_0201);
        check("R5 no pulse", {31'b0, peer_intr_o}, 32'h0);
    endtask

    task automatic t_toggle();
        send(12'hFAA, 8'hC0);
        check("R6 rise pulse", {31'b0, peer_intr_o}, 32'h1);
        check("R9 new contents at pulse", peer_scratch0_o, 32'hC033_AB11);
        @(negedge clk);
        check("R6 single cycle", {31'b0, peer_intr_o}, 32'h0);
        send(12'hFAA, 8'hC0);
        check("R6 same value silent", {31'b0, peer_intr_o}, 32'h0);
        send(12'hFAA, 8'h00);
        check("R6 fall pulse", {31'b0, peer_intr_o}, 32'h1);
        check("R9 valid cleared", {31'b0, peer_fmt_valid_o}, 32'h0);
        send(12'hF80, 8'h01);
        check("R8 doorbell ignored", {31'b0, peer_intr_o}, 32'h0);
        check("R8 regs kept", peer_scratch0_o, 32'h0033_AB11);
    endtask

    task automatic t_doorbell();
        do_reset(1'b1);
        check("R1 reset again", peer_scratch0_o, 32'h0);
        send(12'hFAA, 8'hC0);
        check("R7 flip silent", {31'b0, peer_intr_o}, 32'h0);
        check("R7 bit31 stored", peer_scratch0_o, 32'hC000_0000);
        send(12'hF80, 8'h00);
        check("R7 zero payload silent", {31'b0, peer_intr_o}, 32'h0);
        send(12'hF80, 8'h05);
        check("R7 doorbell pulse", {31'b0, peer_intr_o}, 32'h1);
        @(negedge clk);
        check("R7 single cycle", {31'b0, peer_intr_o}, 32'h0);
    endtask

    initial begin
        do_reset(1'b0);
        @(negedge clk);
        t_reset_state();
        t_reg0_bytes();
        t_reg1_bytes();
        t_reads();
        t_unknown();
        t_toggle();
        t_doorbell();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule